// File: doc/BRIEF.md
# Branch Decision and Target Unit

This unit decides whether a control-transfer instruction redirects the program and where it goes. For flag branches it tests the condition code bits N, Z, V and C against a 4-bit condition selector. The selector covers single-flag tests, unsigned magnitude tests and signed magnitude tests, plus always and never. For counter loops it takes a counter value, optionally decrements or increments it, and then branches on zero or nonzero of the result.

In both cases it adds a sign-extended displacement to the address of the following instruction. The displacement is 8 bits for short branches, 16 bits for long branches and 9 bits for loop branches.

The decision, target and updated counter are registered and appear one cycle after a request is accepted. The caller owns the program counter, the register file and the flags. The unit only reports whether the counter should be written back. It never produces new flag values.

Top module: `bcu_branch_unit`

## Requirements
- R1: After reset, out_valid, taken, cnt_we, target and cnt_out are all zero.
- R2: A request with in_valid high produces out_valid high exactly one clock later; with in_valid low, out_valid is low in the next cycle.
- R3: Flag branches (in_loop=0) with cond_sel 0 are always taken and with cond_sel 1 never taken. Codes 4/5 are taken on C=0/C=1. Codes 6/7 are taken on Z=0/Z=1. Codes 8/9 are taken on V=0/V=1. Codes 10/11 are taken on N=0/N=1.
- R4: Unsigned codes: 2 (higher) is taken when C|Z is 0, and 3 (lower-or-same) is taken when C|Z is 1. Codes 5 and 4 also serve as lower and higher-or-same.
- R5: Signed codes: 12 (greater-or-equal) is taken when N^V is 0. 13 (less) is taken when N^V is 1. 14 (greater) is taken when Z|(N^V) is 0. 15 (less-or-equal) is taken when Z|(N^V) is 1.
- R6: A short flag branch (long_disp=0) targets next_pc plus disp[7:0] sign-extended, modulo 2^16. disp[15:8] is ignored.
- R7: A long flag branch (long_disp=1) targets next_pc plus disp[15:0], modulo 2^16.
- R8: A loop branch (in_loop=1) targets next_pc plus disp[8:0] sign-extended, modulo 2^16. long_disp and disp[15:9] are ignored.
- R9: loop_op 0 tests the counter unchanged and 1 decrements it. loop_op 2 increments it and 3 behaves as test. cnt_out carries the resulting value. cnt_we is 1 only for decrement and increment.
- R10: With cnt_byte=1, the step wraps within cnt_in[7:0], cnt_out[15:8] equals cnt_in[15:8], and the zero test covers only the low 8 bits.
- R11: A loop branch is taken when the resulting counter is zero if loop_on_zero=1, and when it is nonzero if loop_on_zero=0.
- R12: A flag branch reports cnt_we=0 and cnt_out equal to cnt_in. Whenever out_valid is low, taken and cnt_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_loop | input | 1 | 1 = counter loop branch, 0 = flag branch |
| cond_sel | input | 4 | Flag condition selector |
| flags_nzvc | input | 4 | Condition bits {N,Z,V,C} |
| long_disp | input | 1 | Flag branch uses the 16-bit displacement |
| next_pc | input | 16 | Address of the following instruction |
| disp | input | 16 | Raw displacement field |
| loop_op | input | 2 | 0 test, 1 decrement, 2 increment, 3 test |
| loop_on_zero | input | 1 | Loop branches when result is zero |
| cnt_byte | input | 1 | Counter is 8 bits wide |
| cnt_in | input | 16 | Counter value before the loop step |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Branch is taken |
| target | output | 16 | Branch destination |
| cnt_out | output | 16 | Counter after the loop step |
| cnt_we | output | 1 | Counter must be written back |

## Verification
The condition selector is swept over all sixteen flag combinations. This separates the single-flag tests from the unsigned and signed pairs, which differ only where C and Z or N and V disagree.

Target checks use displacements at the edges of each width, with junk in the ignored upper bits and next_pc values close to the 16-bit wrap. Any mistake in the sign-extension width or the carry-out shows up in those results.

Loop cases step 8-bit counters across 0x00/0xFF with a nonzero upper byte, and 16-bit counters across 0x0000/0xFFFF. Test-only requests are mixed in. These cases tell the byte-limited zero test apart from a full-width one, and a write-back from a test-only request.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int ADDR_W  = 16;
  localparam int SHORT_W = 8;
  localparam int LOOP_W  = 9;
  localparam int BYTE_W  = 8;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'd0,  C_NEVER = 4'd1,  C_HI = 4'd2,  C_LS = 4'd3,
    C_CCLR   = 4'd4,  C_CSET  = 4'd5,  C_NE = 4'd6,  C_EQ = 4'd7,
    C_VCLR   = 4'd8,  C_VSET  = 4'd9,  C_PL = 4'd10, C_MI = 4'd11,
    C_GE     = 4'd12, C_LT    = 4'd13, C_GT = 4'd14, C_LE = 4'd15
  } cond_e;

  typedef enum logic [1:0] {
    L_TEST = 2'd0, L_DEC = 2'd1, L_INC = 2'd2, L_TEST2 = 2'd3
  } loop_e;

  typedef enum logic [1:0] {
    D_SHORT = 2'd0, D_LONG = 2'd1, D_LOOP = 2'd2
  } dsel_e;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] nzvc,
  output logic       hit
);
  logic f_n, f_z, f_v, f_c, sgn_lt, uns_ls;

  assign f_n    = nzvc[3];
  assign f_z    = nzvc[2];
  assign f_v    = nzvc[1];
  assign f_c    = nzvc[0];
  assign sgn_lt = f_n ^ f_v;
  assign uns_ls = f_c | f_z;

  // Odd codes are the complement of the preceding even code.
  function automatic logic base_test(input logic [2:0] grp, input logic z,
                                     input logic c, input logic n, input logic v,
                                     input logic lt, input logic ls);
    case (grp)
      3'd0:    base_test = 1'b1;
      3'd1:    base_test = ~ls;
      3'd2:    base_test = ~c;
      3'd3:    base_test = ~z;
      3'd4:    base_test = ~v;
      3'd5:    base_test = ~n;
      3'd6:    base_test = ~lt;
      default: base_test = ~(z | lt);
    endcase
  endfunction

  assign hit = base_test(cond[3:1], f_z, f_c, f_n, f_v, sgn_lt, uns_ls) ^ cond[0];
endmodule

// File: rtl/bcu_loop_eval.sv
module bcu_loop_eval
  import bcu_pkg::*;
#(
  parameter int CNT_W = ADDR_W,
  parameter int LOW_W = BYTE_W
) (
  input  logic [1:0]       op,
  input  logic             byte_mode,
  input  logic             on_zero,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cnt_next,
  output logic             res_zero,
  output logic             hit,
  output logic             we
);
  localparam int HI_W = CNT_W - LOW_W;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic [1:0] o);
    case (o)
      L_DEC:   step = v - 1'b1;
      L_INC:   step = v + 1'b1;
      default: step = v;
    endcase
  endfunction

  logic [CNT_W-1:0] wide_res;
  logic [LOW_W-1:0] narrow_res;
  logic [LOW_W-1:0] narrow_step_in;

  assign narrow_step_in = cnt_in[LOW_W-1:0];
  assign wide_res       = step(cnt_in, op);
  assign narrow_res     = wide_res[LOW_W-1:0];

  assign cnt_next = byte_mode ? {cnt_in[CNT_W-1:LOW_W], narrow_res} : wide_res;
  assign res_zero = byte_mode ? (narrow_res == '0) : (wide_res == '0);
  assign hit      = on_zero ? res_zero : ~res_zero;
  assign we       = (op == L_DEC) || (op == L_INC);

  logic [HI_W-1:0] hi_unused;
  assign hi_unused = '0;
  logic unused_ok;
  assign unused_ok = &{1'b0, narrow_step_in, hi_unused};
endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen
  import bcu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SHORT_W,
  parameter int LW = LOOP_W
) (
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] disp,
  input  logic [1:0]    dsel,
  output logic [AW-1:0] target
);
  localparam int SH_SHORT = AW - SW;
  localparam int SH_LOOP  = AW - LW;

  function automatic logic [AW-1:0] sext_from(input logic [AW-1:0] d, input int sh);
    logic signed [AW-1:0] t;
    t = $signed(d << sh);
    sext_from = AW'(t >>> sh);
  endfunction

  logic [AW-1:0] off;
  always_comb begin
    case (dsel)
      D_SHORT: off = sext_from(disp, SH_SHORT);
      D_LOOP:  off = sext_from(disp, SH_LOOP);
      default: off = disp;
    endcase
  end

  assign target = next_pc + off;
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_loop,
  input  logic [3:0]  cond_sel,
  input  logic [3:0]  flags_nzvc,
  input  logic        long_disp,
  input  logic [15:0] next_pc,
  input  logic [15:0] disp,
  input  logic [1:0]  loop_op,
  input  logic        loop_on_zero,
  input  logic        cnt_byte,
  input  logic [15:0] cnt_in,
  output logic        out_valid,
  output logic        taken,
  output logic [15:0] target,
  output logic [15:0] cnt_out,
  output logic        cnt_we
);
  logic             flag_hit, loop_hit, loop_we, loop_zero;
  logic [ADDR_W-1:0] loop_cnt, tgt_c;
  logic [1:0]        dsel;

  bcu_cond_eval u_cond (
    .cond (cond_sel),
    .nzvc (flags_nzvc),
    .hit  (flag_hit)
  );

  bcu_loop_eval #(.CNT_W(ADDR_W), .LOW_W(BYTE_W)) u_loop (
    .op        (loop_op),
    .byte_mode (cnt_byte),
    .on_zero   (loop_on_zero),
    .cnt_in    (cnt_in),
    .cnt_next  (loop_cnt),
    .res_zero  (loop_zero),
    .hit       (loop_hit),
    .we        (loop_we)
  );

  assign dsel = in_loop ? D_LOOP : (long_disp ? D_LONG : D_SHORT);

  bcu_target_gen #(.AW(ADDR_W), .SW(SHORT_W), .LW(LOOP_W)) u_tgt (
    .next_pc (next_pc),
    .disp    (disp),
    .dsel    (dsel),
    .target  (tgt_c)
  );

  logic take_c, we_c;
  logic [ADDR_W-1:0] cnt_c;
  assign take_c = in_loop ? loop_hit : flag_hit;
  assign we_c   = in_loop & loop_we;
  assign cnt_c  = in_loop ? loop_cnt : cnt_in;

  logic unused_z;
  assign unused_z = loop_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      cnt_we    <= 1'b0;
      target    <= '0;
      cnt_out   <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid & take_c;
      cnt_we    <= in_valid & we_c;
      if (in_valid) begin
        target  <= tgt_c;
        cnt_out <= cnt_c;
      end
    end
  end
endmodule

// File: rtl/bcu_branch_chk.sv
module bcu_branch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_loop,
  input logic [3:0]  cond_sel,
  input logic [1:0]  loop_op,
  input logic        cnt_byte,
  input logic [15:0] cnt_in,
  input logic        out_valid,
  input logic        taken,
  input logic [15:0] cnt_out,
  input logic        cnt_we
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_loop && cond_sel == 4'd0) |=> taken);

  p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_loop && cond_sel == 4'd1) |=> !taken);

  p_test_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_loop && loop_op[0] == loop_op[1]) |=> !cnt_we);

  p_upper_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_loop && cnt_byte) |=> cnt_out[15:8] == $past(cnt_in[15:8]));

  p_flag_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_loop) |=> (!cnt_we && cnt_out == $past(cnt_in)));

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!taken && !cnt_we));
endmodule

bind bcu_branch_unit bcu_branch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_loop   (in_loop),
  .cond_sel  (cond_sel),
  .loop_op   (loop_op),
  .cnt_byte  (cnt_byte),
  .cnt_in    (cnt_in),
  .out_valid (out_valid),
  .taken     (taken),
  .cnt_out   (cnt_out),
  .cnt_we    (cnt_we)
);

// File: tb/bcu_branch_unit_tb.sv
module bcu_branch_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_loop = 1'b0, long_disp = 1'b0;
  logic [3:0]  cond_sel = '0, flags_nzvc = '0;
  logic [15:0] next_pc = '0, disp = '0, cnt_in = '0;
  logic [1:0]  loop_op = '0;
  logic        loop_on_zero = 1'b0, cnt_byte = 1'b0;
  logic        out_valid, taken, cnt_we;
  logic [15:0] target, cnt_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcu_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_loop(in_loop),
    .cond_sel(cond_sel), .flags_nzvc(flags_nzvc), .long_disp(long_disp),
    .next_pc(next_pc), .disp(disp), .loop_op(loop_op),
    .loop_on_zero(loop_on_zero), .cnt_byte(cnt_byte), .cnt_in(cnt_in),
    .out_valid(out_valid), .taken(taken), .target(target),
    .cnt_out(cnt_out), .cnt_we(cnt_we)
  );

  typedef struct packed {
    logic        tk;
    logic [15:0] tg;
    logic [15:0] cn;
    logic        we;
    logic [3:0]  req;
  } exp_t;

  exp_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic flag_model(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return (cy == 0) && (z == 0);
      4'd3:  return (cy == 1) || (z == 1);
      4'd4:  return cy == 0;
      4'd5:  return cy == 1;
      4'd6:  return z == 0;
      4'd7:  return z == 1;
      4'd8:  return v == 0;
      4'd9:  return v == 1;
      4'd10: return n == 0;
      4'd11: return n == 1;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return (z == 0) && (n == v);
      default: return (z == 1) || (n != v);
    endcase
  endfunction

  task automatic fail(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_bad++;
    $display("FAIL %s actual=%h expected=%h", what, act, exp);
  endtask

  // Flag branch request; req tag selects requirement label for reporting.
  task automatic flag_br(input logic [3:0] c, input logic [3:0] f, input logic lng,
                         input logic [15:0] pc, input logic [15:0] d,
                         input logic [15:0] ci, input logic [3:0] req);
    exp_t e;
    logic [15:0] off;
    @(negedge clk);
    in_valid = 1; in_loop = 0; cond_sel = c; flags_nzvc = f; long_disp = lng;
    next_pc = pc; disp = d; cnt_in = ci; loop_op = 2'd1; cnt_byte = 0;
    off = lng ? d : {{8{d[7]}}, d[7:0]};
    e.tk = flag_model(c, f); e.tg = pc + off; e.cn = ci; e.we = 0; e.req = req;
    sb.push_back(e);
  endtask

  task automatic loop_br(input logic [1:0] op, input logic byt, input logic onz,
                         input logic [15:0] ci, input logic [15:0] pc,
                         input logic [15:0] d, input logic [3:0] req);
    exp_t e;
    logic [15:0] res;
    logic [7:0]  lo;
    logic        zero;
    @(negedge clk);
    in_valid = 1; in_loop = 1; cond_sel = 4'd1; flags_nzvc = 4'hF; long_disp = 1;
    next_pc = pc; disp = d; cnt_in = ci; loop_op = op; cnt_byte = byt;
    loop_on_zero = onz;
    if (byt) begin
      lo = ci[7:0];
      if (op == 2'd1) lo = lo - 8'd1;
      else if (op == 2'd2) lo = lo + 8'd1;
      res = {ci[15:8], lo};
      zero = (lo == 8'h00);
    end else begin
      res = ci;
      if (op == 2'd1) res = ci - 16'd1;
      else if (op == 2'd2) res = ci + 16'd1;
      zero = (res == 16'h0000);
    end
    e.tk = onz ? zero : !zero;
    e.tg = pc + {{7{d[8]}}, d[8:0]};
    e.cn = res;
    e.we = (op == 2'd1) || (op == 2'd2);
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_loop = 0;
    end
  endtask

  // Monitor: compares registered results against queued expectations.
  initial begin
    logic pend;
    pend = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          exp_t e;
          if (sb.size() == 0) begin
            fail("R2 unexpected out_valid", 16'(out_valid), 16'h0);
          end else begin
            e = sb.pop_front();
            n_cmp++;
            if (taken !== e.tk) fail($sformatf("R%0d taken", e.req), 16'(taken), 16'(e.tk));
            if (target !== e.tg) fail($sformatf("R%0d target", e.req), target, e.tg);
            if (cnt_out !== e.cn) fail($sformatf("R%0d cnt_out", e.req), cnt_out, e.cn);
            if (cnt_we !== e.we) fail($sformatf("R%0d cnt_we", e.req), 16'(cnt_we), 16'(e.we));
          end
        end else begin
          n_cmp++;
          if (taken !== 1'b0 || cnt_we !== 1'b0)
            fail("R12 quiet outputs", {14'd0, taken, cnt_we}, 16'h0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 0 || taken !== 0 || cnt_we !== 0 || target !== 0 || cnt_out !== 0)
      fail("R1 reset state", target | cnt_out | {13'd0, out_valid, taken, cnt_we}, 16'h0);
    rst_n = 1;

    // R3, R4, R5: every condition code over every flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        flag_br(4'(c), 4'(f), 1'b0, 16'h1000, 16'h0004, 16'h5A5A,
                (c < 2 || (c >= 4 && c < 12)) ? 4'd3 : (c < 4 ? 4'd4 : 4'd5));
      end
    end
    idle(2);

    // R6: short displacement edges, junk upper bits, wrap
    flag_br(4'd0, 4'h0, 1'b0, 16'h2000, 16'hAB7F, 16'h0001, 4'd6);
    flag_br(4'd0, 4'h0, 1'b0, 16'h2000, 16'h3C80, 16'h0002, 4'd6);
    flag_br(4'd0, 4'h0, 1'b0, 16'hFFF0, 16'h0020, 16'h0003, 4'd6);
    flag_br(4'd0, 4'h0, 1'b0, 16'h0010, 16'hFFE0, 16'h0004, 4'd6);
    // R7: long displacement edges
    flag_br(4'd0, 4'h0, 1'b1, 16'h9000, 16'h8000, 16'h0005, 4'd7);
    flag_br(4'd0, 4'h0, 1'b1, 16'h9000, 16'h7FFF, 16'h0006, 4'd7);
    flag_br(4'd1, 4'h0, 1'b1, 16'h0002, 16'h00FE, 16'h0007, 4'd7);
    idle(1);

    // R8: 9-bit loop displacement with junk upper bits
    loop_br(2'd0, 1'b0, 1'b0, 16'h0001, 16'h4000, 16'hFF00, 4'd8);
    loop_br(2'd0, 1'b0, 1'b0, 16'h0001, 16'h4000, 16'h00FF, 4'd8);
    loop_br(2'd0, 1'b0, 1'b0, 16'h0001, 16'h0080, 16'hFE00, 4'd8);
    // R9: test, dec, inc, op 3 as test
    loop_br(2'd0, 1'b0, 1'b1, 16'h1234, 16'h0100, 16'h0010, 4'd9);
    loop_br(2'd1, 1'b0, 1'b0, 16'h1234, 16'h0100, 16'h0010, 4'd9);
    loop_br(2'd2, 1'b0, 1'b0, 16'h1234, 16'h0100, 16'h0010, 4'd9);
    loop_br(2'd3, 1'b0, 1'b0, 16'h0000, 16'h0100, 16'h0010, 4'd9);
    // R10: 8-bit counters wrap and test only low byte
    loop_br(2'd1, 1'b1, 1'b0, 16'hAB00, 16'h0200, 16'h0008, 4'd10);
    loop_br(2'd2, 1'b1, 1'b1, 16'hCDFF, 16'h0200, 16'h0008, 4'd10);
    loop_br(2'd0, 1'b1, 1'b1, 16'h7700, 16'h0200, 16'h0008, 4'd10);
    loop_br(2'd1, 1'b1, 1'b1, 16'h0101, 16'h0200, 16'h0008, 4'd10);
    // R11: zero / nonzero on full-width result
    loop_br(2'd1, 1'b0, 1'b1, 16'h0001, 16'h0300, 16'h01F0, 4'd11);
    loop_br(2'd1, 1'b0, 1'b0, 16'h0001, 16'h0300, 16'h01F0, 4'd11);
    loop_br(2'd2, 1'b0, 1'b1, 16'hFFFF, 16'h0300, 16'h01F0, 4'd11);
    loop_br(2'd2, 1'b0, 1'b0, 16'h00FF, 16'h0300, 16'h01F0, 4'd11);
    idle(4);

    if (sb.size() != 0) fail("R2 missing results", 16'(sb.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule